// File: doc/BRIEF.md
# Stack Call and Interrupt Sequencer

This block is the part of an 8-bit processor core that handles control transfers through the stack. It owns the stack pointer and produces the program counter that results from a subroutine call, a subroutine return, a software break, a maskable or non-maskable interrupt entry, or a return from interrupt. It drives the data memory one byte per cycle. All traffic goes to a fixed stack page, except the two reads of a handler vector.

The surrounding core presents one request at a time while the sequencer is idle. A request is a strobe for call, return, break or interrupt return, or a level on one of the two interrupt lines. Along with it the core supplies the address of the current opcode, the call target and the live status byte. The sequencer reports `busy` while it works. When the work is finished it pulses `done`, and in that cycle `pc_out` and `status_out` carry the values the core should adopt. Fetch, decode and arithmetic are outside this block.

Top module: `stack_call_seq`

## Requirements
- R1: Every stack access places 0x01 on `mem_addr[15:8]`. The low byte is the stack pointer for a push, and the stack pointer plus one for a pull, wrapping modulo 256. `sp_out` resets to 0xFF.
- R2: A push writes at the current pointer and then lowers the pointer by one. A pull raises the pointer by one and then reads at the new value. Each access takes one cycle.
- R3: A call pushes `op_pc`+2, high byte first and then low byte. The resulting PC is `call_target` and the resulting status is `status_in` unchanged.
- R4: A return pulls the low byte and then the high byte, and the resulting PC is {high, low}.
- R5: An interrupt entry pushes `op_pc` high, then `op_pc` low, then the status with bit 5 set and bit 4 clear, leaving the pointer three below its start. It then reads the handler address low byte first, from 0xFFFA/0xFFFB for NMI and from 0xFFFE/0xFFFF for IRQ.
- R6: While `status_in` bit 2 is 1, a request on `irq` alone is not taken: no bus write, no `busy`, and the pointer is unchanged. `nmi` is taken regardless of bit 2.
- R7: A break pushes `op_pc`+2 high then low, then the status with bits 5 and 4 both set, and jumps through 0xFFFE/0xFFFF.
- R8: After any break or interrupt entry, `status_out` equals the captured `status_in` with bit 2 set.
- R9: An interrupt return pulls the status, then PC low, then PC high. `status_out` is the pulled byte with bit 4 cleared and bit 5 set.
- R10: When several requests are present together, the order of precedence is NMI, then unmasked IRQ, then break, then interrupt return, then return, then call. Requests that arrive while `busy` is high are ignored.
- R11: `done` is high for exactly one cycle, in the cycle after the last memory access. `busy` is high from the cycle after acceptance through the `done` cycle, and `mem_we` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_call | input | 1 | Subroutine call request strobe |
| req_ret | input | 1 | Subroutine return request strobe |
| req_brk | input | 1 | Software break request strobe |
| req_rti | input | 1 | Interrupt return request strobe |
| irq | input | 1 | Maskable interrupt line |
| nmi | input | 1 | Non-maskable interrupt line |
| op_pc | input | 16 | Address of the current opcode |
| call_target | input | 16 | Destination of a call |
| status_in | input | 8 | Live status byte (bit 2 = interrupt disable) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| pc_out | output | 16 | Resulting program counter, valid with `done` |
| status_out | output | 8 | Resulting status byte, valid with `done` |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two situations can land in the same cycle. In the first, an interrupt line and a software strobe arrive together at an idle cycle. In the second, a new strobe arrives while an earlier sequence is still stepping through its bytes. The bench presents NMI, IRQ and break in one cycle, and also pairs of software strobes, with the interrupt-disable bit both set and clear. It also raises a return strobe and NMI in the middle of a call. A reference model keeps its own stack image and pointer, and it judges each case by comparing the address, write enable and write data in every cycle, the final PC, the final status and the pointer.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_VEC_L,
    ST_VEC_H,
    ST_PULL_P,
    ST_PULL_L,
    ST_PULL_H,
    ST_FIN
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_CALL,
    OP_RET,
    OP_BRK,
    OP_RTI,
    OP_IRQ,
    OP_NMI
  } seq_op_t;

  // status byte bit positions
  localparam int unsigned SB_IDIS = 2;
  localparam int unsigned SB_BRK  = 4;
  localparam int unsigned SB_ONE  = 5;

  // image of the status as written to the stack
  function automatic logic [7:0] stacked_status(input logic [7:0] s, input logic from_brk);
    logic [7:0] r;
    r         = s;
    r[SB_ONE] = 1'b1;
    r[SB_BRK] = from_brk;
    return r;
  endfunction

  // status as taken back from the stack: the break bit is not a real flag
  function automatic logic [7:0] restored_status(input logic [7:0] s);
    logic [7:0] r;
    r         = s;
    r[SB_ONE] = 1'b1;
    r[SB_BRK] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/stkseq_arb.sv
module stkseq_arb
  import stkseq_pkg::*;
(
  input  logic    req_call,
  input  logic    req_ret,
  input  logic    req_brk,
  input  logic    req_rti,
  input  logic    irq,
  input  logic    nmi,
  input  logic    irq_mask,
  output logic    any_req,
  output seq_op_t win_op
);

  always_comb begin
    any_req = 1'b1;
    win_op  = OP_CALL;
    if (nmi)                    win_op = OP_NMI;
    else if (irq && !irq_mask)  win_op = OP_IRQ;
    else if (req_brk)           win_op = OP_BRK;
    else if (req_rti)           win_op = OP_RTI;
    else if (req_ret)           win_op = OP_RET;
    else if (req_call)          win_op = OP_CALL;
    else                        any_req = 1'b0;
  end

endmodule

// File: rtl/stkseq_sp.sv
module stkseq_sp #(
  parameter int unsigned        SP_W     = 8,
  parameter logic [SP_W-1:0]    SP_RESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pull,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_addr
);

  localparam logic [SP_W-1:0] SP_STEP = {{(SP_W-1){1'b0}}, 1'b1};

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_d;
  logic            sp_en;
  logic [SP_W-1:0] sp_inc;

  assign sp_inc = sp_q + SP_STEP;

  always_comb begin
    sp_en = push | pull;
    sp_d  = sp_q;
    if (push)      sp_d = sp_q - SP_STEP;
    else if (pull) sp_d = sp_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RESET;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp      = sp_q;
  assign sp_addr = pull ? sp_inc : sp_q;

endmodule

// File: rtl/stkseq_fsm.sv
module stkseq_fsm
  import stkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  seq_op_t    start_op,
  output seq_state_t state,
  output seq_op_t    op
);

  seq_state_t state_q, state_d;
  seq_op_t    op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          unique case (start_op)
            OP_RET:  state_d = ST_PULL_L;
            OP_RTI:  state_d = ST_PULL_P;
            default: state_d = ST_PUSH_H;
          endcase
        end
      end
      ST_PUSH_H: state_d = ST_PUSH_L;
      ST_PUSH_L: state_d = (op_q == OP_CALL) ? ST_FIN : ST_PUSH_P;
      ST_PUSH_P: state_d = ST_VEC_L;
      ST_VEC_L:  state_d = ST_VEC_H;
      ST_VEC_H:  state_d = ST_FIN;
      ST_PULL_P: state_d = ST_PULL_L;
      ST_PULL_L: state_d = ST_PULL_H;
      ST_PULL_H: state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= OP_CALL;
    else if (start) op_q <= start_op;
  end

  assign state = state_q;
  assign op    = op_q;

endmodule

// File: rtl/stack_call_seq.sv
module stack_call_seq
  import stkseq_pkg::*;
#(
  parameter int unsigned          DATA_W     = 8,
  parameter int unsigned          ADDR_W     = 2 * DATA_W,
  parameter logic [DATA_W-1:0]    STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0]    SP_RESET   = 8'hFF,
  parameter logic [ADDR_W-1:0]    VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0]    VEC_IRQ    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_call,
  input  logic              req_ret,
  input  logic              req_brk,
  input  logic              req_rti,
  input  logic              irq,
  input  logic              nmi,
  input  logic [ADDR_W-1:0] op_pc,
  input  logic [ADDR_W-1:0] call_target,
  input  logic [DATA_W-1:0] status_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] status_out,
  output logic [DATA_W-1:0] sp_out,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] RET_SKIP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // request selection and sequencing
  logic       any_req;
  seq_op_t    win_op;
  seq_state_t state;
  seq_op_t    op_q;
  logic       start;

  stkseq_arb u_arb (
    .req_call (req_call),
    .req_ret  (req_ret),
    .req_brk  (req_brk),
    .req_rti  (req_rti),
    .irq      (irq),
    .nmi      (nmi),
    .irq_mask (status_in[SB_IDIS]),
    .any_req  (any_req),
    .win_op   (win_op)
  );

  assign start = (state == ST_IDLE) && any_req;

  stkseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .start_op (win_op),
    .state    (state),
    .op       (op_q)
  );

  // stack pointer
  logic              do_push;
  logic              do_pull;
  logic [DATA_W-1:0] sp_addr;

  assign do_push = (state == ST_PUSH_H) || (state == ST_PUSH_L) || (state == ST_PUSH_P);
  assign do_pull = (state == ST_PULL_P) || (state == ST_PULL_L) || (state == ST_PULL_H);

  stkseq_sp #(
    .SP_W     (DATA_W),
    .SP_RESET (SP_RESET)
  ) u_sp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push    (do_push),
    .pull    (do_pull),
    .sp      (sp_out),
    .sp_addr (sp_addr)
  );

  // operands captured at acceptance
  logic [ADDR_W-1:0] ret_pc_q, ret_pc_d;
  logic [ADDR_W-1:0] tgt_q;
  logic [DATA_W-1:0] stat_q;

  always_comb begin
    ret_pc_d = op_pc;
    if (win_op == OP_CALL || win_op == OP_BRK) ret_pc_d = op_pc + RET_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
      tgt_q    <= '0;
      stat_q   <= '0;
    end else if (start) begin
      ret_pc_q <= ret_pc_d;
      tgt_q    <= call_target;
      stat_q   <= status_in;
    end
  end

  // memory bus
  logic [ADDR_W-1:0] vec_base;

  assign vec_base = (op_q == OP_NMI) ? VEC_NMI : VEC_IRQ;

  always_comb begin
    mem_addr  = {STACK_PAGE, sp_addr};
    mem_we    = do_push;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_H: mem_wdata = ret_pc_q[ADDR_W-1:DATA_W];
      ST_PUSH_L: mem_wdata = ret_pc_q[DATA_W-1:0];
      ST_PUSH_P: mem_wdata = stacked_status(stat_q, op_q == OP_BRK);
      ST_VEC_L:  mem_addr  = vec_base;
      ST_VEC_H:  mem_addr  = vec_base + ONE_A;
      default:   mem_wdata = '0;
    endcase
  end

  // byte holders for pulls and vector reads
  logic              lo_en;
  logic              pst_en;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] pst_q;

  assign lo_en  = (state == ST_VEC_L) || (state == ST_PULL_L);
  assign pst_en = (state == ST_PULL_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pst_q <= '0;
    else if (pst_en) pst_q <= restored_status(mem_rdata);
  end

  // results
  logic              res_en;
  logic [ADDR_W-1:0] pc_d, pc_q;
  logic [DATA_W-1:0] st_d, st_q;

  always_comb begin
    res_en = 1'b0;
    pc_d   = {mem_rdata, lo_q};
    st_d   = stat_q;
    unique case (state)
      ST_PUSH_L: begin
        res_en = (op_q == OP_CALL);
        pc_d   = tgt_q;
      end
      ST_VEC_H: begin
        res_en         = 1'b1;
        st_d[SB_IDIS]  = 1'b1;
      end
      ST_PULL_H: begin
        res_en = 1'b1;
        if (op_q == OP_RTI) st_d = pst_q;
      end
      default: res_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      st_q <= '0;
    end else if (res_en) begin
      pc_q <= pc_d;
      st_q <= st_d;
    end
  end

  assign pc_out     = pc_q;
  assign status_out = st_q;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
  parameter int unsigned       DATA_W     = 8,
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_call,
  input logic              req_ret,
  input logic              req_brk,
  input logic              req_rti,
  input logic              irq,
  input logic              nmi,
  input logic [ADDR_W-1:0] op_pc,
  input logic [DATA_W-1:0] status_in,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic [DATA_W-1:0] sp_out,
  input logic              busy,
  input logic              done
);

  AST_PUSH_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE && mem_addr[DATA_W-1:0] == sp_out)); // R1

  AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 1'b1)); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq && status_in[2] && !nmi && !req_call && !req_ret && !req_brk && !req_rti)
      |=> !busy); // R6

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && nmi) |=> (busy && mem_we && mem_wdata == $past(op_pc[ADDR_W-1:DATA_W]))); // R6

  AST_SP_STILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp_out)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R11

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R11

  AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R11

endmodule

bind stack_call_seq stkseq_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .STACK_PAGE (STACK_PAGE)
) u_stkseq_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_call   (req_call),
  .req_ret    (req_ret),
  .req_brk    (req_brk),
  .req_rti    (req_rti),
  .irq        (irq),
  .nmi        (nmi),
  .op_pc      (op_pc),
  .status_in  (status_in),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_we     (mem_we),
  .sp_out     (sp_out),
  .busy       (busy),
  .done       (done)
);

// File: tb/stack_call_seq_bench.sv
`timescale 1ns/1ps
module stack_call_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        req_call, req_ret, req_brk, req_rti, irq, nmi;
  logic [15:0] op_pc, call_target;
  logic [7:0]  status_in;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic [15:0] pc_out;
  logic [7:0]  status_out;
  logic [7:0]  sp_out;
  logic        busy, done;

  stack_call_seq u_stack_call_seq (
    .clk(clk), .rst_n(rst_n),
    .req_call(req_call), .req_ret(req_ret), .req_brk(req_brk), .req_rti(req_rti),
    .irq(irq), .nmi(nmi), .op_pc(op_pc), .call_target(call_target),
    .status_in(status_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .status_out(status_out), .sp_out(sp_out), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory: stack page array plus two vectors
  logic [7:0] stk [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) stk[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_we && mem_addr[15:8] == 8'h01) begin
      stk[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always_comb begin
    if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
    else begin
      case (mem_addr)
        16'hFFFA: mem_rdata = 8'h34;
        16'hFFFB: mem_rdata = 8'h12;
        16'hFFFE: mem_rdata = 8'hCD;
        16'hFFFF: mem_rdata = 8'hAB;
        default:  mem_rdata = 8'h00;
      endcase
    end
  end

  // reference model state
  int          n_chk = 0;
  int          n_err = 0;
  logic [7:0]  m_stk [256];
  logic [7:0]  m_sp;
  logic [15:0] q_addr [$];
  logic        q_we   [$];
  logic [7:0]  q_wd   [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_push(input logic [7:0] v);
    q_addr.push_back({8'h01, m_sp}); q_we.push_back(1'b1); q_wd.push_back(v);
    m_stk[m_sp] = v;
    m_sp = m_sp - 8'd1;
  endtask

  task automatic m_pull(output logic [7:0] v);
    m_sp = m_sp + 8'd1;
    v = m_stk[m_sp];
    q_addr.push_back({8'h01, m_sp}); q_we.push_back(1'b0); q_wd.push_back(8'h00);
  endtask

  task automatic m_read(input logic [15:0] a);
    q_addr.push_back(a); q_we.push_back(1'b0); q_wd.push_back(8'h00);
  endtask

  // one request cycle; bits of rq: 0 call, 1 ret, 2 brk, 3 rti
  task automatic run(input logic [3:0] rq, input logic i_irq, input logic i_nmi,
                     input logic [15:0] pc, input logic [15:0] tgt, input logic [7:0] st,
                     input bit glitch, input string tag);
    int          kind;
    logic [15:0] e_pc, rpc;
    logic [7:0]  e_st, lo, hi, ps;
    logic [7:0]  sp0;
    @(negedge clk);
    req_call = rq[0]; req_ret = rq[1]; req_brk = rq[2]; req_rti = rq[3];
    irq = i_irq; nmi = i_nmi; op_pc = pc; call_target = tgt; status_in = st;
    if (i_nmi)                kind = 5;
    else if (i_irq && !st[2]) kind = 4;
    else if (rq[2])           kind = 2;
    else if (rq[3])           kind = 3;
    else if (rq[1])           kind = 1;
    else if (rq[0])           kind = 0;
    else                      kind = -1;
    sp0 = m_sp; e_pc = 16'h0; e_st = st;
    q_addr.delete(); q_we.delete(); q_wd.delete();
    case (kind)
      0: begin rpc = pc + 16'd2; m_push(rpc[15:8]); m_push(rpc[7:0]); e_pc = tgt; end
      1: begin m_pull(lo); m_pull(hi); e_pc = {hi, lo}; end
      2, 4, 5: begin
        rpc = (kind == 2) ? pc + 16'd2 : pc;
        m_push(rpc[15:8]); m_push(rpc[7:0]);
        m_push({st[7:6], 1'b1, (kind == 2), st[3:0]});
        if (kind == 5) begin m_read(16'hFFFA); m_read(16'hFFFB); e_pc = 16'h1234; end
        else           begin m_read(16'hFFFE); m_read(16'hFFFF); e_pc = 16'hABCD; end
        e_st = st | 8'h04;
      end
      3: begin m_pull(ps); m_pull(lo); m_pull(hi); e_pc = {hi, lo};
         e_st = {ps[7:6], 1'b1, 1'b0, ps[3:0]}; end
      default: ;
    endcase
    @(negedge clk);
    req_call = 0; req_ret = 0; req_brk = 0; req_rti = 0; irq = 0; nmi = 0;
    if (kind < 0) begin
      chk({tag, " R6 busy"}, busy, 0);
      chk({tag, " R6 we"},   mem_we, 0);
      chk({tag, " R6 sp"},   sp_out, sp0);
      return;
    end
    foreach (q_addr[k]) begin
      if (k > 0) @(negedge clk);
      if (glitch && k == 0) begin req_ret = 1; nmi = 1; irq = 1; status_in = 8'h00; end
      else if (glitch && k == 1) begin req_ret = 0; nmi = 0; irq = 0; end
      chk({tag, " R11 busy"}, busy, 1);
      chk({tag, " R2 done low"}, done, 0);
      chk({tag, " R1 addr"}, mem_addr, q_addr[k]);
      chk({tag, " R2 we"}, mem_we, q_we[k]);
      if (q_we[k]) chk({tag, " R3/R5/R7 wdata"}, mem_wdata, q_wd[k]);
    end
    @(negedge clk);
    chk({tag, " R11 done"}, done, 1);
    chk({tag, " R3/R4/R5 pc"}, pc_out, e_pc);
    chk({tag, " R8/R9 status"}, status_out, e_st);
    chk({tag, " R2 sp"}, sp_out, m_sp);
    @(negedge clk);
    chk({tag, " R11 done drop"}, done, 0);
    chk({tag, " R11 idle"}, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R11 act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0;
    req_call = 0; req_ret = 0; req_brk = 0; req_rti = 0; irq = 0; nmi = 0;
    op_pc = 0; call_target = 0; status_in = 0;
    for (int i = 0; i < 256; i++) m_stk[i] = 8'(i) ^ 8'h5A;
    m_sp = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset sp", sp_out, 8'hFF);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset we", mem_we, 0);

    run(4'b0001, 0, 0, 16'h1000, 16'h2000, 8'h00, 0, "R3 call");
    run(4'b0001, 0, 0, 16'h20FE, 16'h3000, 8'h81, 0, "R3 call carry");
    run(4'b0010, 0, 0, 16'h0000, 16'h0000, 8'h81, 0, "R4 ret");
    run(4'b0010, 0, 0, 16'h0000, 16'h0000, 8'h00, 0, "R4 ret2");
    run(4'b0000, 1, 0, 16'h3456, 16'h0000, 8'hC3, 0, "R5 irq");
    run(4'b1000, 0, 0, 16'h0000, 16'h0000, 8'h00, 0, "R9 rti");
    run(4'b0100, 0, 0, 16'h4000, 16'h0000, 8'h01, 0, "R7 brk");
    run(4'b1000, 0, 0, 16'h0000, 16'h0000, 8'h00, 0, "R9 rti brk");
    run(4'b0000, 1, 0, 16'h5000, 16'h0000, 8'h04, 0, "R6 masked irq");
    run(4'b0100, 1, 1, 16'h6000, 16'h0000, 8'h04, 0, "R10 nmi wins");
    run(4'b0100, 1, 0, 16'h7000, 16'h0000, 8'h00, 0, "R10 irq over brk");
    run(4'b0100, 1, 0, 16'h7100, 16'h0000, 8'h04, 0, "R10 brk when masked");
    run(4'b1010, 0, 0, 16'h0000, 16'h0000, 8'h00, 0, "R10 rti over ret");
    run(4'b0011, 0, 0, 16'h0000, 16'h0000, 8'h00, 0, "R10 ret over call");
    run(4'b0001, 0, 0, 16'h8000, 16'h9000, 8'h10, 1, "R10 busy ignores");
    for (int n = 0; n < 130; n++)
      run(4'b0001, 0, 0, 16'(n * 3), 16'hA000, 8'h00, 0, "R1 wrap call");
    for (int n = 0; n < 4; n++)
      run(4'b0010, 0, 0, 16'h0000, 16'h0000, 8'h00, 0, "R1 wrap ret");
    run(4'b0000, 0, 1, 16'hBEEF, 16'h0000, 8'hFF, 0, "R5 nmi masked flag");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule